// File: doc/BRIEF.md
# Interleaved Converter Bus Pair Receiver

This block sits on the host side of a dual-channel converter that shares a single 10-bit data bus between its two channels. The converter places a channel A word and then a channel B word on the bus within each sample period, and tags each word with a channel indicator. The receiver runs on a clock at twice the sample rate and samples the bus, the indicator and a bus-valid qualifier on every edge. Bus-valid stands in for the converter's output enable.

Each channel A word is joined with the channel B word on the very next cycle, since both come from the same sampling instant. The receiver converts both words to signed form and presents them together with a single-cycle pair strobe. A static input selects how the converter codes its words: straight offset binary or two's complement. Broken sequences are recorded in a sticky error flag and the incomplete pair is dropped. Such a sequence is a repeated channel A word, or a channel B word with no channel A word before it.

Top module: `adc_pair_rx`

## Requirements
- R1: An indicator value of 1 marks a channel A word and 0 marks a channel B word. A channel A word followed, on the next clock, by a valid channel B word yields one pair. `pair_valid` is high for exactly one cycle, two clock edges after the edge that samples the channel B word. At that time `ch_a` and `ch_b` carry the pair.
- R2: With `twos_mode` = 0 (offset binary), each output equals the input word with its MSB inverted. Code 10'b10_0000_0000 therefore comes out as signed zero, 10'h000 as -512 and 10'h3FF as +511.
- R3: With `twos_mode` = 1, each output equals the input word bit for bit.
- R4: Two consecutive valid channel A words set `seq_err`. The first A word is discarded, and the second one pairs with a channel B word that follows it.
- R5: A valid channel B word without a directly preceding valid channel A word sets `seq_err` and produces no pair.
- R6: Once set, `seq_err` stays high until reset, and pairs continue to be emitted while it is high.
- R7: Words sampled with `bus_valid` low are dropped. They cause no error, and a low cycle clears any held channel A word, so a channel B word after the gap is an orphan.
- R8: During and right after reset, `pair_valid` and `seq_err` are 0 and no channel A word is held.
- R9: `pair_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| twos_mode | input | 1 | Static coding select: 1 two's complement, 0 offset binary |
| bus_valid | input | 1 | High when the bus carries a driven word |
| ab_flag | input | 1 | Channel indicator: 1 channel A, 0 channel B |
| bus_data | input | 10 | Shared converter data word |
| pair_valid | output | 1 | One-cycle strobe for a completed pair |
| ch_a | output | 10 | Signed channel A sample of the last pair |
| ch_b | output | 10 | Signed channel B sample of the last pair |
| seq_err | output | 1 | Sticky sequence error flag |

## Verification
The assertions check several properties on every cycle. The strobe never repeats on back-to-back cycles, and the error flag never falls. Every strobe is traced back to a valid channel A word followed by a valid channel B word at the bus pins. Output values are tied to the coding rule for the mid-scale code and for two's complement. An orphan channel B word must always leave the flag raised. Only the bench scenarios show the rest: every 10-bit code converted in both codings, the discard of the first of two A words, and a bus-valid gap clearing the held word. They also show that a second reset clears the sticky flag.

// File: rtl/adc_pair_rx.sv
module adc_pair_rx #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         twos_mode,
  input  logic         bus_valid,
  input  logic         ab_flag,
  input  logic [W-1:0] bus_data,
  output logic         pair_valid,
  output logic [W-1:0] ch_a,
  output logic [W-1:0] ch_b,
  output logic         seq_err
);
  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  logic         s_vld, s_ab;
  logic [W-1:0] s_dat;
  logic         have_a;
  logic [W-1:0] a_hold;

  wire [W-1:0] s_signed = twos_mode ? s_dat : (s_dat ^ MSB_MASK);
  wire         take_a   = s_vld & s_ab;
  wire         take_b   = s_vld & ~s_ab;
  wire         complete = take_b & have_a;
  wire         broken   = (take_a & have_a) | (take_b & ~have_a);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_vld      <= 1'b0;
      s_ab       <= 1'b0;
      s_dat      <= '0;
      have_a     <= 1'b0;
      a_hold     <= '0;
      pair_valid <= 1'b0;
      ch_a       <= '0;
      ch_b       <= '0;
      seq_err    <= 1'b0;
    end else begin
      s_vld      <= bus_valid;
      s_ab       <= ab_flag;
      s_dat      <= bus_data;
      pair_valid <= complete;
      if (complete) begin
        ch_a <= a_hold;
        ch_b <= s_signed;
      end
      if (broken) seq_err <= 1'b1;
      if (take_a) begin
        have_a <= 1'b1;
        a_hold <= s_signed;
      end else begin
        have_a <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_pair_rx_chk.sv
module adc_pair_rx_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         twos_mode,
  input logic         bus_valid,
  input logic         ab_flag,
  input logic [W-1:0] bus_data,
  input logic         pair_valid,
  input logic [W-1:0] ch_a,
  input logic [W-1:0] ch_b,
  input logic         seq_err
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  wire ready = (warm == 2'd3);

  AST_PV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err); // R6
  AST_PAIR_HAS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pair_valid) |-> $past(bus_valid && !ab_flag, 2)); // R1
  AST_PAIR_HAS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pair_valid) |-> $past(bus_valid && ab_flag, 3)); // R1
  AST_MID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pair_valid && !twos_mode && $past(bus_data, 2) == MID) |-> (ch_b == '0)); // R2
  AST_TWOS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pair_valid && twos_mode) |-> (ch_b == $past(bus_data, 2) && ch_a == $past(bus_data, 3))); // R3
  AST_ORPHAN_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(bus_valid && !ab_flag, 2) && !$past(bus_valid && ab_flag, 3)) |-> seq_err); // R5
endmodule

bind adc_pair_rx adc_pair_rx_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .twos_mode(twos_mode), .bus_valid(bus_valid),
  .ab_flag(ab_flag), .bus_data(bus_data), .pair_valid(pair_valid),
  .ch_a(ch_a), .ch_b(ch_b), .seq_err(seq_err)
);

// File: tb/test_adc_pair_rx.sv
`timescale 1ns/1ps
module test_adc_pair_rx;
  localparam int W = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic twos_mode = 1'b0;
  logic bus_valid = 1'b0;
  logic ab_flag = 1'b0;
  logic [W-1:0] bus_data = '0;
  logic pair_valid, seq_err;
  logic [W-1:0] ch_a, ch_b;

  int checks = 0;
  int errors = 0;

  logic m_have;
  logic [W-1:0] m_a;
  logic m_err;
  logic d1_pv, d2_pv, d1_err, d2_err;
  logic [W-1:0] d1_a, d2_a, d1_b, d2_b;

  adc_pair_rx #(.W(W)) i_adc_pair_rx (
    .clk(clk), .rst_n(rst_n), .twos_mode(twos_mode), .bus_valid(bus_valid),
    .ab_flag(ab_flag), .bus_data(bus_data), .pair_valid(pair_valid),
    .ch_a(ch_a), .ch_b(ch_b), .seq_err(seq_err)
  );

  always #2 clk = ~clk;

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [W-1:0] conv(input logic [W-1:0] d);
    return twos_mode ? d : (d ^ {1'b1, {(W-1){1'b0}}});
  endfunction

  task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    m_have = 1'b0; m_a = '0; m_err = 1'b0;
    d1_pv = 1'b0; d2_pv = 1'b0; d1_err = 1'b0; d2_err = 1'b0;
    d1_a = '0; d2_a = '0; d1_b = '0; d2_b = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_valid = 1'b0; ab_flag = 1'b0; bus_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    check("R8", "pair_valid after reset", {9'b0, pair_valid}, '0);
    check("R8", "seq_err after reset", {9'b0, seq_err}, '0);
  endtask

  task automatic step(input logic v, input logic ab, input logic [W-1:0] d, input string tag);
    logic pv, er;
    logic [W-1:0] ea, eb;
    @(negedge clk);
    check(tag, "pair_valid", {9'b0, pair_valid}, {9'b0, d2_pv});
    check(tag, "seq_err", {9'b0, seq_err}, {9'b0, d2_err});
    if (d2_pv) begin
      check(tag, "ch_a", ch_a, d2_a);
      check(tag, "ch_b", ch_b, d2_b);
    end
    bus_valid = v; ab_flag = ab; bus_data = d;
    pv = 1'b0; ea = d1_a; eb = d1_b;
    if (v && ab) begin
      if (m_have) m_err = 1'b1;
      m_have = 1'b1;
      m_a = conv(d);
    end else if (v) begin
      if (m_have) begin
        pv = 1'b1; ea = m_a; eb = conv(d);
      end else begin
        m_err = 1'b1;
      end
      m_have = 1'b0;
    end else begin
      m_have = 1'b0;
    end
    er = m_err;
    d2_pv = d1_pv; d2_err = d1_err; d2_a = d1_a; d2_b = d1_b;
    d1_pv = pv; d1_err = er; d1_a = ea; d1_b = eb;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    clear_model();
    do_reset();

    // R1: basic pairs
    step(1'b1, 1'b1, 10'h155, "R1");
    step(1'b1, 1'b0, 10'h0AA, "R1");
    step(1'b1, 1'b1, 10'h200, "R1");
    step(1'b1, 1'b0, 10'h1FF, "R1");
    idle(3, "R1");

    // R2: every code, offset binary
    twos_mode = 1'b0;
    for (int c = 0; c < 1024; c++) begin
      step(1'b1, 1'b1, W'(c), "R2");
      step(1'b1, 1'b0, W'(1023 - c), "R2");
    end
    idle(3, "R2");

    // R3: every code, two's complement
    twos_mode = 1'b1;
    idle(2, "R3");
    for (int c = 0; c < 1024; c++) begin
      step(1'b1, 1'b1, W'(c), "R3");
      step(1'b1, 1'b0, W'(c ^ 10'h2A5), "R3");
    end
    idle(3, "R3");
    twos_mode = 1'b0;
    idle(2, "R3");

    // R7: invalid cycles dropped, held A cleared without error
    step(1'b1, 1'b1, 10'h011, "R7");
    step(1'b0, 1'b0, 10'h022, "R7");
    step(1'b1, 1'b1, 10'h033, "R7");
    step(1'b1, 1'b0, 10'h044, "R7");
    step(1'b0, 1'b1, 10'h3FF, "R7");
    idle(3, "R7");

    // R5: orphan B
    do_reset();
    step(1'b1, 1'b0, 10'h123, "R5");
    idle(3, "R5");

    // R4: repeated A
    do_reset();
    step(1'b1, 1'b1, 10'h005, "R4");
    step(1'b1, 1'b1, 10'h007, "R4");
    step(1'b1, 1'b0, 10'h009, "R4");
    idle(3, "R4");

    // R6: flag stays set while pairs continue
    for (int c = 0; c < 16; c++) begin
      step(1'b1, 1'b1, W'(c * 37), "R6");
      step(1'b1, 1'b0, W'(c * 59), "R6");
    end
    idle(3, "R6");

    // R7: B after gap is an orphan
    do_reset();
    step(1'b1, 1'b1, 10'h100, "R7");
    step(1'b0, 1'b1, 10'h101, "R7");
    step(1'b1, 1'b0, 10'h102, "R7");
    idle(3, "R7");

    do_reset();
    idle(2, "R8");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule